// File: doc/BRIEF.md
# Bit-Stream Phase-Aligning Resynchronizer

This block sits in front of a decimation filter and takes in six one-bit 64fs sample streams on a shared bit clock. The bit clock can arrive from outside, or the block can make it by dividing the 512fs system clock. Each stream is held in two candidate registers. The early copy is loaded on each rising bit-clock edge. The late copy takes the early copy on the next falling edge, so it trails by half a bit period.

After a qualified initialisation release or sync pulse, the block waits for the first falling bit-clock edge. From that edge on it tracks the bit-clock phase. At the next rising edge of the output word clock it looks at the bit-clock level and fixes which copy feeds the filter. If the bit clock is high at that edge, the early copy has just changed, so the late copy is used. If the bit clock is low, the early copy is used. The choice is then kept until the next resync.

One strobe per bit period hands the chosen copy downstream. A mute request stays up across the realignment and for a number of word-clock periods that depends on the output rate. This covers the sample that may be lost or repeated during the realignment.

Top module: `dsd_phase_resync`

## Requirements
- R1: The early copy holds the stream values sampled at the most recent rising bit-clock edge. The late copy holds the value the early copy had at the most recent falling edge.
- R2: With `bclk_dir`=1 the bit clock is generated internally with a period of 8 system clocks. It is high for the first 4 clocks after initialisation release, and `bclk_oe` follows `bclk_dir`. With `bclk_dir`=0 the `bclk_in` pin is used.
- R3: While initialisation is active, the generated bit clock `bclk_out` is held high.
- R4: A request needs at least 6 consecutive system-clock samples: `init_n` low, or `sync_req` high. A shorter pulse has no effect on mute, selection or strobes.
- R5: A resync is the release of a qualified `init_n` low, or a qualified `sync_req` pulse. After a resync, the first falling bit-clock edge arms the block. The next rising `wclk` edge then selects the late copy if the bit clock is high at that edge, and the early copy otherwise. The selection changes at no other time.
- R6: `samp_vld` pulses once per bit period. With the early copy selected it pulses 2 system clocks after the cycle in which the falling `bclk_in` level is applied. With the late copy selected it pulses 2 system clocks after the rising level is applied.
- R7: With the early copy selected, `samp_data` is the value sampled at the same bit period's rising edge. With the late copy selected, it is the value sampled one rising edge earlier.
- R8: `mute_req` is 1 from reset, during initialisation and from each resync. It falls at the Nth rising `wclk` edge after the selection is fixed. N is 10 for `rate_sel`=00, 18 for 01 and 36 for 1x.
- R9: Between reset or initialisation and the first selection, `samp_vld` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 512fs system clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_dir | input | 1 | 1: generate bit clock, 0: use `bclk_in` |
| bclk_in | input | 1 | External bit clock |
| dsd_in | input | 6 | Six one-bit sample streams |
| init_n | input | 1 | Active-low initialisation request |
| sync_req | input | 1 | Active-high resync request |
| wclk | input | 1 | Output word clock, rising edge is the event |
| rate_sel | input | 2 | Output rate: 00 fs, 01 2fs, 1x 4fs |
| bclk_out | output | 1 | Generated bit clock |
| bclk_oe | output | 1 | Drive enable for the bit-clock pin |
| samp_data | output | 6 | Selected sample, one bit per stream |
| samp_vld | output | 1 | One-cycle sample strobe |
| mute_req | output | 1 | Downstream mute request |

## Verification
The following are checked on every cycle:
- the generated clock is forced high during initialisation;
- qualified requests arrive as single-cycle events;
- strobes never come back-to-back and never appear before a selection exists;
- the selection moves only at an armed word edge;
- mute is released only on a word edge.

Some behaviour only the scenarios can show. These are:
- which copy is picked for each of the eight word-edge phases within a bit period;
- the exact sample values and strobe positions that follow;
- the exact mute length per rate;
- the ignoring of short pulses;
- the period and phase of the generated clock after release.

// File: rtl/dsd_rs_pkg.sv
package dsd_rs_pkg;

    typedef enum logic [1:0] {
        RATE_1X     = 2'b00,
        RATE_2X     = 2'b01,
        RATE_4X     = 2'b10,
        RATE_4X_ALT = 2'b11
    } rate_e;

    typedef enum logic {
        SRC_EARLY = 1'b0,
        SRC_LATE  = 1'b1
    } src_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } bck_edge_t;

    localparam int MUTE_LONGEST = 36;
    localparam int MUTE_W       = $clog2(MUTE_LONGEST + 1);

    function automatic int unsigned mute_words(rate_e r);
        case (r)
            RATE_1X: return 10;
            RATE_2X: return 18;
            default: return MUTE_LONGEST;
        endcase
    endfunction

endpackage

// File: rtl/dsd_pulse_qual.sv
module dsd_pulse_qual #(
    parameter int MIN_LEN = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic ev
);
    localparam int CW = $clog2(MIN_LEN + 1);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || !level)
            run_q <= '0;
        else if (run_q != CW'(MIN_LEN))
            run_q <= run_q + 1'b1;
    end

    assign ev = level && (run_q == CW'(MIN_LEN - 1));

    // R4
    single_event_chk: assert property (@(posedge clk) disable iff (rst)
        ev |=> !ev);

endmodule

// File: rtl/dsd_bclk_gen.sv
module dsd_bclk_gen #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    output logic bclk
);
    localparam int W = $clog2(DIV);

    logic [W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst || hold)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end

    assign bclk = ~div_q[W-1];

    // R3
    held_high_chk: assert property (@(posedge clk) disable iff (rst)
        hold |=> bclk);

endmodule

// File: rtl/dsd_capture.sv
module dsd_capture
    import dsd_rs_pkg::*;
#(
    parameter int NCH = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  bck_edge_t      edge_i,
    input  logic [NCH-1:0] din,
    input  src_e           src,
    input  logic           enable,
    output logic [NCH-1:0] samp_data,
    output logic           samp_vld
);
    logic [NCH-1:0] early_q, late_q, out_q;
    logic           vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            early_q <= '0;
            late_q  <= '0;
            out_q   <= '0;
            vld_q   <= 1'b0;
        end else begin
            if (edge_i.rise) early_q <= din;
            if (edge_i.fall) late_q  <= early_q;
            vld_q <= 1'b0;
            if (enable && src == SRC_EARLY && edge_i.fall) begin
                out_q <= early_q;
                vld_q <= 1'b1;
            end
            if (enable && src == SRC_LATE && edge_i.rise) begin
                out_q <= late_q;
                vld_q <= 1'b1;
            end
        end
    end

    assign samp_data = out_q;
    assign samp_vld  = vld_q;

    // R6
    strobe_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        samp_vld |=> !samp_vld);

endmodule

// File: rtl/dsd_phase_ctl.sv
module dsd_phase_ctl
    import dsd_rs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  init_hold,
    input  logic  resync_ev,
    input  logic  bck_fall,
    input  logic  bck_level,
    input  logic  wclk_rise,
    input  rate_e rate,
    output src_e  sel,
    output logic  locked,
    output logic  mute_req
);
    logic              pending_q, armed_q, locked_q, mute_q;
    logic [MUTE_W-1:0] left_q;
    src_e              sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= 1'b0;
            armed_q   <= 1'b0;
            locked_q  <= 1'b0;
            mute_q    <= 1'b1;
            left_q    <= '0;
            sel_q     <= SRC_EARLY;
        end else if (resync_ev) begin
            pending_q <= 1'b1;
            armed_q   <= 1'b0;
            mute_q    <= 1'b1;
            left_q    <= '0;
        end else if (init_hold) begin
            pending_q <= 1'b0;
            armed_q   <= 1'b0;
            locked_q  <= 1'b0;
            mute_q    <= 1'b1;
            left_q    <= '0;
        end else if (pending_q && bck_fall) begin
            pending_q <= 1'b0;
            armed_q   <= 1'b1;
        end else if (armed_q && wclk_rise) begin
            armed_q  <= 1'b0;
            sel_q    <= bck_level ? SRC_LATE : SRC_EARLY;
            locked_q <= 1'b1;
            left_q   <= MUTE_W'(mute_words(rate));
        end else if (wclk_rise && left_q != '0) begin
            left_q <= left_q - 1'b1;
            if (left_q == MUTE_W'(1))
                mute_q <= 1'b0;
        end
    end

    assign sel      = sel_q;
    assign locked   = locked_q;
    assign mute_req = mute_q;

    // R5
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(armed_q && wclk_rise) |=> $stable(sel_q));

    // R8
    mute_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(mute_q) |-> $past(wclk_rise));

endmodule

// File: rtl/dsd_phase_resync.sv
module dsd_phase_resync
    import dsd_rs_pkg::*;
#(
    parameter int NCH     = 6,
    parameter int BCK_DIV = 8,
    parameter int MIN_REQ = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bclk_dir,
    input  logic           bclk_in,
    input  logic [NCH-1:0] dsd_in,
    input  logic           init_n,
    input  logic           sync_req,
    input  logic           wclk,
    input  logic [1:0]     rate_sel,
    output logic           bclk_out,
    output logic           bclk_oe,
    output logic [NCH-1:0] samp_data,
    output logic           samp_vld,
    output logic           mute_req
);
    logic           bclk_q, init_n_q, sync_q, wclk_q, wclk_d, bck_d;
    logic [NCH-1:0] dsd_q;
    logic           init_act_q;
    logic           init_ev, sync_ev, resync_ev;
    logic           gen_bclk, bck_level;
    bck_edge_t      bck_edge;
    src_e           sel;
    logic           locked;

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q   <= 1'b0;
            dsd_q    <= '0;
            init_n_q <= 1'b1;
            sync_q   <= 1'b0;
            wclk_q   <= 1'b0;
            wclk_d   <= 1'b0;
            bck_d    <= 1'b0;
        end else begin
            bclk_q   <= bclk_in;
            dsd_q    <= dsd_in;
            init_n_q <= init_n;
            sync_q   <= sync_req;
            wclk_q   <= wclk;
            wclk_d   <= wclk_q;
            bck_d    <= bck_level;
        end
    end

    dsd_pulse_qual #(.MIN_LEN(MIN_REQ)) u_init_qual (
        .clk(clk), .rst(rst), .level(~init_n_q), .ev(init_ev)
    );

    dsd_pulse_qual #(.MIN_LEN(MIN_REQ)) u_sync_qual (
        .clk(clk), .rst(rst), .level(sync_q), .ev(sync_ev)
    );

    always_ff @(posedge clk) begin
        if (rst)
            init_act_q <= 1'b0;
        else if (init_ev)
            init_act_q <= 1'b1;
        else if (init_n_q)
            init_act_q <= 1'b0;
    end

    assign resync_ev = sync_ev || (init_act_q && init_n_q);

    dsd_bclk_gen #(.DIV(BCK_DIV)) u_gen (
        .clk(clk), .rst(rst), .hold(init_act_q), .bclk(gen_bclk)
    );

    assign bck_level     = bclk_dir ? gen_bclk : bclk_q;
    assign bck_edge.rise = bck_level && !bck_d;
    assign bck_edge.fall = !bck_level && bck_d;

    dsd_phase_ctl u_ctl (
        .clk       (clk),
        .rst       (rst),
        .init_hold (init_act_q),
        .resync_ev (resync_ev),
        .bck_fall  (bck_edge.fall),
        .bck_level (bck_level),
        .wclk_rise (wclk_q && !wclk_d),
        .rate      (rate_e'(rate_sel)),
        .sel       (sel),
        .locked    (locked),
        .mute_req  (mute_req)
    );

    dsd_capture #(.NCH(NCH)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .edge_i    (bck_edge),
        .din       (dsd_q),
        .src       (sel),
        .enable    (locked),
        .samp_data (samp_data),
        .samp_vld  (samp_vld)
    );

    assign bclk_out = gen_bclk;
    assign bclk_oe  = bclk_dir;

    // R9
    no_strobe_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
        !locked |=> !samp_vld);

endmodule

// File: tb/dsd_phase_resync_tb.sv
module dsd_phase_resync_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bclk_dir = 1'b0;
    logic       bclk_in = 1'b0;
    logic [5:0] dsd_in = '0;
    logic       init_n = 1'b1;
    logic       sync_req = 1'b0;
    logic       wclk = 1'b0;
    logic [1:0] rate_sel = 2'b00;
    logic       bclk_out, bclk_oe, samp_vld, mute_req;
    logic [5:0] samp_data;

    int  total = 0;
    int  bad = 0;
    int  cyc = 0;
    int  woff = 0;
    bit  wclk_on = 0;
    bit  chk_strobe = 0;
    bit  exp_late = 0;
    bit  init_pin = 1;
    bit  sync_pin = 0;

    always #5 clk = ~clk;

    dsd_phase_resync u_dut (
        .clk(clk), .rst(rst), .bclk_dir(bclk_dir), .bclk_in(bclk_in),
        .dsd_in(dsd_in), .init_n(init_n), .sync_req(sync_req), .wclk(wclk),
        .rate_sel(rate_sel), .bclk_out(bclk_out), .bclk_oe(bclk_oe),
        .samp_data(samp_data), .samp_vld(samp_vld), .mute_req(mute_req)
    );

    function automatic logic [5:0] dval(int k);
        return 6'((k * 29 + (k >> 2) * 7 + 3) & 63);
    endfunction

    function automatic int mute_len(int r);
        return (r == 0) ? 10 : (r == 1) ? 18 : 36;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at sample %0d: actual=%0h expected=%0h", req, cyc - 1, act, exp);
        end
    endtask

    // R6, R7, R1: strobe position and value from the slave-mode stimulus pattern
    task automatic check_strobe(int s);
        int  u   = s - 2;
        int  ph  = u % 8;
        int  k   = u / 8;
        bit  ev  = exp_late ? (ph == 0) : (ph == 4);
        chk("R6 strobe position", samp_vld, ev);
        if (ev)
            chk("R7 R1 sample value", samp_data, exp_late ? dval(k - 1) : dval(k));
    endtask

    task automatic step();
        int ph, k;
        @(negedge clk);
        if (chk_strobe) check_strobe(cyc);
        ph = cyc % 8;
        k  = cyc / 8;
        bclk_in  = (ph < 4);
        dsd_in   = (ph < 4) ? dval(k) : dval(k + 1);
        wclk     = wclk_on && (((cyc + 16 - woff) % 16) < 8);
        sync_req = sync_pin;
        init_n   = init_pin;
        cyc++;
    endtask

    task automatic goto(int s);
        while (cyc <= s) step();
    endtask

    task automatic lock_case(int p);
        int t0, tc, n;
        chk_strobe = 0;
        woff = p;
        rate_sel = 2'(p % 3);
        n = mute_len(p % 3);
        t0 = ((cyc / 16) + 2) * 16;
        while (cyc < t0) step();
        sync_pin = 1;
        repeat (6) step();
        sync_pin = 0;
        goto(t0 + 10);
        chk("R8 mute after resync", mute_req, 1'b1);
        tc = t0 + 16 + p;
        goto(tc + 16 * n + 1);
        chk("R8 mute before last word edge", mute_req, 1'b1);
        step();
        chk("R8 mute released", mute_req, 1'b0);
        exp_late = (p < 4);
        chk_strobe = 1;
        repeat (40) step();
        chk_strobe = 0;
    endtask

    initial begin : main
        int i0, r;
        repeat (3) step();
        chk("R8 reset mute", mute_req, 1'b1);
        chk("R9 reset strobe", samp_vld, 1'b0);
        chk("R3 reset bclk", bclk_out, 1'b1);
        rst = 1'b0;

        // R9: no selection yet, so no strobes even with clocks running
        wclk_on = 1;
        for (int i = 0; i < 40; i++) begin
            step();
            chk("R9 no strobe before lock", samp_vld, 1'b0);
        end

        // R5: every word-edge phase within a bit period
        for (int p = 0; p < 8; p++) lock_case(p);

        // R4: short sync pulse changes nothing (selection stays early from p=7)
        sync_pin = 1;
        repeat (5) step();
        sync_pin = 0;
        chk_strobe = 1;
        repeat (80) step();
        chk_strobe = 0;
        chk("R4 short sync mute", mute_req, 1'b0);

        // R4: short init pulse changes nothing
        init_pin = 0;
        repeat (5) step();
        init_pin = 1;
        chk_strobe = 1;
        repeat (80) step();
        chk_strobe = 0;
        chk("R4 short init mute", mute_req, 1'b0);

        // R2, R3: master mode across initialisation
        bclk_dir = 1'b1;
        init_pin = 0;
        i0 = cyc;
        goto(i0 + 8);
        chk("R3 bclk held high", bclk_out, 1'b1);
        chk("R2 output enable", bclk_oe, 1'b1);
        chk("R8 mute in init", mute_req, 1'b1);
        chk("R9 no strobe in init", samp_vld, 1'b0);
        goto(i0 + 11);
        chk("R3 bclk still high", bclk_out, 1'b1);
        init_pin = 1;
        r = cyc;
        for (int s = r + 2; s < r + 34; s++) begin
            goto(s);
            chk("R2 generated bclk", bclk_out, ((s - r - 2) % 8) < 4);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule